// File: doc/BRIEF.md
# Two-Channel Sequential Break Sequencer

This block turns the per-cycle match pulses of two break channels, A and B, into a single user-break interrupt request. It also keeps a sticky condition flag for each channel. In independent mode, either channel can raise the request on its own. In sequential mode, channel B only counts once channel A has matched earlier. There is one exception. When channel A is set up as a fetch-before-execution, instruction-fetch condition, matches of A and B in the same cycle also break.

A 16-bit execution counter can be added to channel B's condition. Only channel B matches decrement it. With the counter enabled, channel B is satisfied only on the match that finds the counter at 1. In sequential mode, that match must also follow a channel A match.

Software loads the counter, writes the mode bit and clears the flags through simple write strobes. The request comes out one cycle after the qualifying match.

Top module: `seq_break_unit`

## Requirements
- R1: After reset, `brk_req`, `flag_a` and `flag_b` are 0, `exec_cnt` is 0 and the sequencer is disarmed.
- R2: With `seq_mode`=0, a `hit_a` pulse raises `brk_req` and sets `flag_a` on the following cycle.
- R3: With `seq_mode`=0, a satisfied channel B condition raises `brk_req` and sets `flag_b` on the following cycle. "Satisfied" means `hit_b` with `cnt_en`=0, or `hit_b` with `cnt_en`=1 while `exec_cnt`=1.
- R4: With `seq_mode`=1, a `hit_b` that arrives while disarmed and without `hit_a` raises no request and leaves `flag_b` at 0.
- R5: With `seq_mode`=1, a `hit_a` arms the sequencer. A later satisfied B condition raises `brk_req` and sets `flag_b`, and that break disarms the sequencer, so a further lone `hit_b` does not break.
- R6: With `seq_mode`=1 and the sequencer disarmed, `hit_a` and `hit_b` in the same cycle raise no request when `a_pre_exec` and `a_is_fetch` are not both 1. `flag_a` is still set and `flag_b` stays 0.
- R7: With `seq_mode`=1 and both `a_pre_exec` and `a_is_fetch` at 1, same-cycle `hit_a` and a satisfied B condition raise `brk_req` and set both flags.
- R8: With `cnt_en`=1, each `hit_b` decrements `exec_cnt` by 1. The B condition is satisfied only when `exec_cnt` is 1 before the decrement.
- R9: `hit_a` never changes `exec_cnt`. With `cnt_en`=0, `hit_b` does not change it either.
- R10: `exec_cnt` saturates at 0. A `hit_b` at 0 leaves it at 0 and does not satisfy the B condition.
- R11: The flags stay set until `clr_flag_a` / `clr_flag_b` is pulsed. If a set and a clear of the same flag occur in one cycle, the set wins.
- R12: A `mode_wr` pulse disarms the sequencer, so a following lone `hit_b` does not break in sequential mode.
- R13: `cnt_wr` loads `cnt_wdata` into `exec_cnt` on the next cycle. The load takes priority over a decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_mode | input | 1 | 1 = sequential (B after A), 0 = independent |
| mode_wr | input | 1 | Mode register write strobe; disarms the sequencer |
| a_pre_exec | input | 1 | Channel A breaks before execution |
| a_is_fetch | input | 1 | Channel A is programmed for instruction fetch |
| hit_a | input | 1 | Channel A match pulse |
| hit_b | input | 1 | Channel B match pulse |
| cnt_en | input | 1 | Execution-count condition enabled for channel B |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 16 | Counter load value |
| clr_flag_a | input | 1 | Clear channel A flag |
| clr_flag_b | input | 1 | Clear channel B flag |
| brk_req | output | 1 | User-break interrupt request (one-cycle pulse per qualifying match) |
| flag_a | output | 1 | Sticky channel A condition-match flag |
| flag_b | output | 1 | Sticky channel B condition-match flag |
| exec_cnt | output | 16 | Execution counter value |

## Verification
Every result is registered exactly once: the request, both flags, the counter and the armed state all update on the edge that samples the match, load or clear. The bench drives each stimulus on a falling edge and waits one rising edge. It then reads the outputs on the next falling edge, which is one cycle after the stimulus. Arming, counter loads and flag clears are given their own earlier cycles, so the checked cycle carries only the combination under test. A lingering one-cycle pulse therefore cannot pass for a fresh one.

// File: rtl/seq_break_unit.sv
module seq_break_unit #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seq_mode,
  input  logic          mode_wr,
  input  logic          a_pre_exec,
  input  logic          a_is_fetch,
  input  logic          hit_a,
  input  logic          hit_b,
  input  logic          cnt_en,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          clr_flag_a,
  input  logic          clr_flag_b,
  output logic          brk_req,
  output logic          flag_a,
  output logic          flag_b,
  output logic [CW-1:0] exec_cnt
);
  logic armed;

  wire cnt_zero = exec_cnt == '0;
  wire b_cond   = hit_b && (!cnt_en || exec_cnt == CW'(1));
  wire same_ok  = hit_a && a_pre_exec && a_is_fetch;
  wire seq_fire = seq_mode && b_cond && (armed || same_ok);
  wire fire     = seq_mode ? seq_fire : (hit_a || b_cond);
  wire set_b    = seq_mode ? seq_fire : b_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_req  <= 1'b0;
      flag_a   <= 1'b0;
      flag_b   <= 1'b0;
      armed    <= 1'b0;
      exec_cnt <= '0;
    end else begin
      brk_req <= fire;
      if (hit_a) flag_a <= 1'b1;
      else if (clr_flag_a) flag_a <= 1'b0;
      if (set_b) flag_b <= 1'b1;
      else if (clr_flag_b) flag_b <= 1'b0;
      if (mode_wr || seq_fire) armed <= 1'b0;
      else if (seq_mode && hit_a) armed <= 1'b1;
      if (cnt_wr) exec_cnt <= cnt_wdata;
      else if (cnt_en && hit_b && !cnt_zero) exec_cnt <= exec_cnt - CW'(1);
    end
  end

  a_r2_indep_a_breaks: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_mode && hit_a |=> brk_req && flag_a);
  a_r4_b_first_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    seq_mode && hit_b && !hit_a && !armed |=> !brk_req);
  a_r9_a_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a && !hit_b && !cnt_wr |=> $stable(exec_cnt));
  a_r10_floor: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zero && !cnt_wr |=> exec_cnt == '0);
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && hit_b && !cnt_wr && !cnt_zero |=> exec_cnt == $past(exec_cnt) - CW'(1));
  a_r11_sticky_a: assert property (@(posedge clk) disable iff (!rst_n)
    flag_a && !clr_flag_a |=> flag_a);
  a_r11_sticky_b: assert property (@(posedge clk) disable iff (!rst_n)
    flag_b && !clr_flag_b |=> flag_b);
endmodule

// File: tb/test_seq_break_unit.sv
module test_seq_break_unit;
  localparam int PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic seq_mode = 0, mode_wr = 0, a_pre_exec = 0, a_is_fetch = 0;
  logic hit_a = 0, hit_b = 0, cnt_en = 0, cnt_wr = 0, clr_flag_a = 0, clr_flag_b = 0;
  logic [15:0] cnt_wdata = '0;
  logic brk_req, flag_a, flag_b;
  logic [15:0] exec_cnt;
  int nchk = 0, nerr = 0;

  always #(PERIOD/2) clk = ~clk;

  seq_break_unit i_seq_break_unit (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    {mode_wr, hit_a, hit_b, cnt_wr, clr_flag_a, clr_flag_b} = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic load(input logic [15:0] v);
    cnt_wr = 1; cnt_wdata = v; mode_wr = 1; clr_flag_a = 1; clr_flag_b = 1;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 brk", brk_req, 0); chk("R1 fa", flag_a, 0);
    chk("R1 fb", flag_b, 0); chk("R1 cnt", exec_cnt, 0);
    rst_n = 1;
    @(negedge clk);

    // R13 load, R8 third B breaks with count 3
    seq_mode = 0; cnt_en = 1; load(16'd3);
    chk("R13 load", exec_cnt, 3);
    for (int k = 0; k < 3; k++) begin
      hit_b = 1; step();
      chk("R8 brk", brk_req, k == 2);
      chk("R8 cnt", exec_cnt, 2 - k);
    end
    hit_b = 1; step();
    chk("R10 sat", exec_cnt, 0); chk("R10 nobrk", brk_req, 0);
    repeat (3) step();
    chk("R11 sticky", flag_b, 1);
    clr_flag_b = 1; step();
    chk("R11 cleared", flag_b, 0);

    // R5 disarm after break, R12 mode write disarm
    seq_mode = 1; cnt_en = 0; load(16'd0);
    hit_a = 1; step(); chk("R5 a alone", brk_req, 0);
    hit_b = 1; step(); chk("R5 a then b", brk_req, 1);
    hit_b = 1; step(); chk("R5 disarmed", brk_req, 0);
    hit_a = 1; step();
    mode_wr = 1; step();
    hit_b = 1; step(); chk("R12 mode write", brk_req, 0);

    // sweep: prior armed, preset count, all 64 input combos
    for (int arm = 0; arm < 2; arm++)
      for (int c = 0; c < 3; c++)
        for (int v = 0; v < 64; v++) begin
          logic s, pre, ifc, ce, a, b, bh, eb, efb;
          {s, pre, ifc, ce, a, b} = 6'(v);
          seq_mode = 1; cnt_en = 0; load(16'(c));
          if (arm == 1) begin hit_a = 1; step(); end
          clr_flag_a = 1; clr_flag_b = 1; step();
          seq_mode = s; a_pre_exec = pre; a_is_fetch = ifc; cnt_en = ce;
          hit_a = a; hit_b = b;
          step();
          bh = b && (!ce || c == 1);
          if (s) begin
            eb = bh && (arm == 1 || (a && pre && ifc));
            efb = eb;
          end else begin
            eb = a || bh;
            efb = bh;
          end
          chk(s ? (arm == 1 ? "R5 sweep brk" : (a && b ? (pre && ifc ? "R7 sweep brk" : "R6 sweep brk") : "R4 sweep brk"))
                : (a ? "R2 sweep brk" : "R3 sweep brk"), brk_req, eb);
          chk("R2/R6 flag_a sweep", flag_a, a);
          chk("R3/R7 flag_b sweep", flag_b, efb);
          chk((ce && b) ? "R8 R10 sweep cnt" : "R9 sweep cnt", exec_cnt,
              (ce && b) ? (c == 0 ? 0 : c - 1) : c);
          seq_mode = 0; a_pre_exec = 0; a_is_fetch = 0; cnt_en = 0;
        end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule